// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller connects a synchronous single-beat request/acknowledge bus to a 32K x 8 asynchronous static RAM. The RAM has active-low select, output-enable and write-enable strobes, a 15-bit address and a shared 8-bit data bus. The bus is driven through separate output, output-enable and input signals. Each accepted request becomes one strobe sequence whose phases are counted in clock cycles. The counts come from minimum timing values given in nanoseconds together with the clock period.

A request is accepted only while the controller is idle, and it is acknowledged in the same cycle. A read returns its byte together with a one-cycle done pulse. A write also ends with a done pulse. After every read the controller inserts turnaround cycles, so that it never drives the data bus while the memory may still be driving it. Between requests the memory is held deselected and the controller's data driver is off.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and when idle, select, output enable and write enable are high (1 = inactive), the data driver is off, and ack and done are low.
- R2: ack is high in the same cycle as req only while the controller is idle. A req held high during an access or a turnaround is not acknowledged.
- R3: A read holds select and output enable low, write enable high and the address stable for RD_CYC cycles. RD_CYC is the largest of the cycle-time, select-access and output-enable-access minimums (70, 70 and 35 ns), each converted by ceiling division with a floor of one cycle. This gives 9 cycles at 8 ns.
- R4: Read data is captured at the clock edge that ends the last read cycle. done is high for exactly one cycle, starting in the cycle after the last read cycle or after the last write-recovery cycle.
- R5: After a read, for ceil(30 ns / period) cycles (4 at 8 ns), all strobes stay high, the driver stays off and no request is acknowledged. The driver is never on while output enable is low.
- R6: During a write, output enable stays high for the whole cycle. The data driver turns on one cycle before write enable falls.
- R7: Write enable is held low for max(ceil(45/T), ceil(60/T)-1, ceil(30/T)-1) cycles, where T is the clock period. Select and address stay stable from the setup cycle onwards. Address/select valid time before write enable rises is at least 60 ns, and data is valid at least 30 ns before write enable rises.
- R8: The driver stays on for exactly one cycle after write enable rises. Select stays low for at least ceil(70/T) cycles per access.
- R9: The byte written to the memory is wdata at addr, and a later read of that address returns it on rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | Request accepted (same cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with done |
| sram_addr_o | output | 15 | Memory address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_dq_o | output | 8 | Data driven to memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | 8 | Data from memory |

## Verification
At 8 ns the expected cycle counts after an accepting edge are as follows. A read keeps its strobes low for 9 cycles, and done and rdata appear in the 10th cycle, followed by 4 turnaround cycles. A write is 1 setup cycle, 7 write-enable cycles and 1 recovery cycle, with done in the 10th cycle. The bench's memory model samples every strobe at the falling edge. It hands out valid read data only once 9 consecutive read cycles have passed, and returns a poison byte before that. It measures each pulse width and setup window when the pulse ends, and it checks done in the cycle where select rises. A scoreboard pops one expected item per done pulse and compares read data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_TURN, ST_WSET, ST_WPUL, ST_WREC
  } state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  state_e            state_d_i,
  input  logic              drv_d_i,
  input  logic              capture_i,
  input  logic              done_d_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_cs_no   <= 1'b1;
      sram_oe_no   <= 1'b1;
      sram_we_no   <= 1'b1;
      sram_dq_oe_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      sram_cs_no   <= (state_d_i == ST_IDLE) || (state_d_i == ST_TURN);
      sram_oe_no   <= (state_d_i != ST_RD);
      sram_we_no   <= (state_d_i != ST_WPUL);
      sram_dq_oe_o <= drv_d_i;
      done_o       <= done_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o <= '0;
      sram_dq_o   <= '0;
      rdata_o     <= '0;
    end else begin
      if (accept_i) begin
        sram_addr_o <= addr_i;
        sram_dq_o   <= wdata_i;
      end
      if (capture_i) rdata_o <= sram_dq_i;
    end
  end

  a_r6_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);
  a_r6_drv_before_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(sram_dq_oe_o));
  a_r8_release_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o ##1 !sram_dq_oe_o);
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_no_drive_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> !sram_dq_oe_o);
  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o));
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_ACS_NS  = 70,
  parameter int unsigned T_AOE_NS  = 35,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_WP_NS   = 45,
  parameter int unsigned T_AW_NS   = 60,
  parameter int unsigned T_DW_NS   = 30,
  parameter int unsigned T_HZ_NS   = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned RD_CYC  = umax(ns2cyc(T_RC_NS, CLK_NS),
                                         umax(ns2cyc(T_ACS_NS, CLK_NS), ns2cyc(T_AOE_NS, CLK_NS)));
  // setup cycle already counts toward address and data windows
  localparam int unsigned WE_CYC  = umax(ns2cyc(T_WP_NS, CLK_NS),
                                         umax(ns2cyc(T_AW_NS, CLK_NS) - 1, ns2cyc(T_DW_NS, CLK_NS) - 1));
  localparam int unsigned WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WE_CYC + 2) ? (WC_CYC - 1 - WE_CYC) : 1;
  localparam int unsigned TA_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WE_CYC), umax(REC_CYC, TA_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  state_e           state_q, state_d;
  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             drv_d, capture, done_d;

  assign ack_o = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i)    state_d = we_i ? ST_WSET : ST_RD;
      ST_RD:   if (tmr_zero) state_d = ST_TURN;
      ST_TURN: if (tmr_zero) state_d = ST_IDLE;
      ST_WSET:               state_d = ST_WPUL;
      ST_WPUL: if (tmr_zero) state_d = ST_WREC;
      ST_WREC: if (tmr_zero) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_RD:   tmr_val = CNT_W'(RD_CYC - 1);
      ST_TURN: tmr_val = CNT_W'(TA_CYC - 1);
      ST_WPUL: tmr_val = CNT_W'(WE_CYC - 1);
      ST_WREC: tmr_val = CNT_W'(REC_CYC - 1);
      default: tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign capture  = (state_q == ST_RD) && tmr_zero;
  assign done_d   = capture || ((state_q == ST_WREC) && tmr_zero);
  assign drv_d    = (state_d == ST_WSET) || (state_d == ST_WPUL) ||
                    ((state_d == ST_WREC) && (state_q == ST_WPUL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (ack_o),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .state_d_i    (state_d),
    .drv_d_i      (drv_d),
    .capture_i    (capture),
    .done_d_i     (done_d),
    .sram_dq_i    (sram_dq_i),
    .sram_addr_o  (sram_addr_o),
    .sram_cs_no   (sram_cs_no),
    .sram_oe_no   (sram_oe_no),
    .sram_we_no   (sram_we_no),
    .sram_dq_o    (sram_dq_o),
    .sram_dq_oe_o (sram_dq_oe_o),
    .rdata_o      (rdata_o),
    .done_o       (done_o)
  );

  a_r2_ack_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (sram_cs_no && sram_we_no && sram_oe_no));
  a_r5_turn_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_oe_no) && sram_we_no) |-> (!ack_o && sram_cs_no));
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int PER     = 8;
  localparam int RD_NEED = (70 + PER - 1) / PER;
  localparam int WP_NEED = (45 + PER - 1) / PER;
  localparam int AW_NEED = (60 + PER - 1) / PER;
  localparam int DW_NEED = (30 + PER - 1) / PER;
  localparam int WC_NEED = (70 + PER - 1) / PER;
  localparam int TA_NEED = (30 + PER - 1) / PER;

  logic clk = 0, rst_ni = 0;
  logic req_i = 0, we_i = 0;
  logic [14:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic ack_o, done_o, sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o;
  logic [7:0] rdata_o, sram_dq_o, sram_dq_i;
  logic [14:0] sram_addr_o;

  int checks = 0, errors = 0, cyc = 0;

  always #(PER/2) clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ack_o(ack_o), .done_o(done_o), .rdata_o(rdata_o),
    .sram_addr_o(sram_addr_o), .sram_cs_no(sram_cs_no), .sram_oe_no(sram_oe_no),
    .sram_we_no(sram_we_no), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i(sram_dq_i));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model and strobe timing checker
  logic [7:0] mmem [int];
  logic [7:0] shadow [int];
  bit p_cs = 1, p_we = 1, p_rd = 0, p_dqoe = 0, last_rd = 0, rel_pend = 0;
  logic [14:0] p_addr = '0;
  int cs_lo = 0, rd_cnt = 0, we_cnt = 0, dq_cnt = 0, tail = 0, ta_left = 0;
  int cs_end = 0, dq_end = 0;
  logic [14:0] w_addr; logic [7:0] w_data;

  initial sram_dq_i = 8'hEE;

  always @(negedge clk) if (rst_ni) begin
    bit rd, drv;
    cyc++;
    rd = !sram_cs_no && !sram_oe_no && sram_we_no;
    if (!sram_cs_no) begin
      cs_lo = p_cs ? 1 : cs_lo + 1;
      if (!p_cs && sram_addr_o != p_addr) chk(0, "R3/R7 addr stable", sram_addr_o, p_addr);
    end
    if (!sram_cs_no && !p_cs && sram_addr_o == p_addr && cs_lo == 2) chk(1, "R3 addr stable", 0, 0);
    if (!sram_cs_no && p_cs) last_rd = !sram_oe_no;
    rd_cnt = rd ? (p_rd ? rd_cnt + 1 : 1) : 0;
    sram_dq_i = (rd && rd_cnt >= RD_NEED) ?
                (mmem.exists(int'(sram_addr_o)) ? mmem[int'(sram_addr_o)] : 8'h00) : 8'hEE;
    if (rd) begin drv = 1; tail = TA_NEED; end
    else if (tail > 0) begin drv = 1; tail--; end
    else drv = 0;
    if (drv && sram_dq_oe_o) chk(0, "R5 bus contention", 1, 0);
    dq_cnt = sram_dq_oe_o ? (p_dqoe ? dq_cnt + 1 : 1) : 0;
    if (rel_pend) begin chk(!sram_dq_oe_o, "R8 driver release", sram_dq_oe_o, 0); rel_pend = 0; end
    if (!sram_we_no) begin
      if (p_we) begin
        chk(p_dqoe, "R6 driver before we", p_dqoe, 1);
        we_cnt = 0;
      end
      chk(sram_oe_no, "R6 oe high in write", sram_oe_no, 1);
      we_cnt++; cs_end = cs_lo; dq_end = dq_cnt;
      w_addr = sram_addr_o; w_data = sram_dq_o;
    end else if (!p_we) begin
      chk(we_cnt >= WP_NEED, "R7 we pulse", we_cnt, WP_NEED);
      chk(cs_end >= AW_NEED, "R7 addr valid to end", cs_end, AW_NEED);
      chk(dq_end >= DW_NEED, "R7 data setup", dq_end, DW_NEED);
      chk(sram_dq_oe_o, "R8 driver held one cycle", sram_dq_oe_o, 1);
      mmem[int'(w_addr)] = w_data;
      rel_pend = 1;
    end
    if (sram_cs_no && !p_cs) begin
      chk(cs_lo >= WC_NEED, "R8 cycle time", cs_lo, WC_NEED);
      chk(done_o, "R4 done after access", done_o, 1);
      ta_left = last_rd ? TA_NEED : 0;
    end
    if (ta_left > 0) begin
      chk(sram_cs_no && !sram_dq_oe_o && !ack_o, "R5 turnaround",
          {sram_cs_no, sram_dq_oe_o, ack_o}, 3'b100);
      ta_left--;
    end
    if (!sram_cs_no && ack_o) chk(0, "R2 ack while busy", 1, 0);
    p_cs = sram_cs_no; p_we = sram_we_no; p_rd = rd; p_dqoe = sram_dq_oe_o; p_addr = sram_addr_o;
  end

  // scoreboard
  typedef struct { bit rd; logic [7:0] data; logic [14:0] addr; } exp_t;
  exp_t q[$];
  bit p_done = 0;

  always @(negedge clk) if (rst_ni) begin
    if (p_done) chk(!done_o, "R4 done one cycle", done_o, 0);
    if (done_o) begin
      if (q.size() == 0) chk(0, "R4 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        if (e.rd) chk(rdata_o == e.data, "R9 read data", rdata_o, e.data);
        else      chk(mmem.exists(int'(e.addr)) && mmem[int'(e.addr)] == e.data,
                      "R9 written byte", mmem.exists(int'(e.addr)) ? mmem[int'(e.addr)] : 'hFFF, e.data);
      end
    end
    p_done = done_o;
  end

  task automatic op(input bit w, input logic [14:0] a, input logic [7:0] d);
    exp_t e;
    req_i = 1; we_i = w; addr_i = a; wdata_i = d;
    do @(negedge clk); while (!ack_o);
    e.rd = !w; e.addr = a;
    if (w) begin e.data = d; shadow[int'(a)] = d; end
    else e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    q.push_back(e);
    @(posedge clk); #1;
    req_i = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sram_cs_no && sram_oe_no && sram_we_no && !sram_dq_oe_o && !ack_o && !done_o,
        "R1 reset state", {sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o}, 4'b1110);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(sram_cs_no && sram_oe_no && sram_we_no && !sram_dq_oe_o && !done_o,
        "R1 idle state", {sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o}, 4'b1110);
    req_i = 1; we_i = 0; #1;
    chk(ack_o, "R2 ack same cycle in idle", ack_o, 1);
    req_i = 0;
    @(posedge clk); #1;
    op(1, 15'h0000, 8'hA5);
    op(1, 15'h7FFF, 8'h5A);
    op(0, 15'h0000, 8'h00);
    op(0, 15'h7FFF, 8'h00);
    op(1, 15'h1234, 8'h3C);
    op(0, 15'h1234, 8'h00);
    op(0, 15'h2222, 8'h00);
    op(1, 15'h1234, 8'hFF);
    op(0, 15'h1234, 8'h00);
    for (int i = 0; i < 40; i++) begin
      logic [14:0] a;
      a = 15'((i * 4099 + 17) & 15'h0FFF);
      op((i % 3) != 2, a, 8'((i * 37) ^ 8'h6B));
    end
    for (int i = 0; i < 40; i++) op(0, 15'((i * 4099 + 17) & 15'h0FFF), 8'h00);
    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R4 all done pulses seen", q.size(), 0);
    chk(sram_cs_no && !sram_dq_oe_o, "R1 idle after traffic", sram_cs_no, 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end
endmodule